// File: doc/BRIEF.md
# Synchronous Read Master with Wait-State Stretching

This block issues single read transfers to a memory over a clocked processor-to-memory bus. A request is a start pulse plus an address. The controller then steps through three phases. In the first phase it places the address on the bus. In the second phase it also raises the read strobe. In the third phase it returns the captured word together with a one-cycle done pulse.

The memory side can stretch a transfer. It pulls its ready line low as soon as it sees the read strobe. While ready is low, the controller adds whole-clock wait states and keeps the address and strobe on the bus. Data is captured on the first clock edge at which ready is seen high.

A small memory model is included in the same top for test. Its number of wait states is a parameter from 0 to 3. A setting of 1 reproduces a memory that answers one and a half clock periods after the strobe.

Top module: `rdbus_read_sys`

## Requirements
- R1: While reset is held, and right after it, the block is idle: bus_rd is 0, bus_addr is 0, busy is 0, done is 0 and rd_data is 0.
- R2: In the first cycle after the clock edge that samples req_start high in idle, bus_addr equals the requested address, bus_rd is 0 and busy is 1.
- R3: bus_rd is 1 in the next cycle. bus_addr keeps its value in every cycle in which bus_rd is 1, even if req_addr changes.
- R4: With no wait states, the word is captured on the edge that ends the single read-strobe cycle, and done is 1 in the third cycle after the sampling edge.
- R5: Each rising edge that finds bus_rd high and bus_ready low adds exactly one more read-strobe cycle. So bus_rd is high for 1 + W cycles, where W is the wait count.
- R6: rd_data equals the value on bus_data at the edge where bus_ready was first seen high. It is never a value from a not-ready cycle.
- R7: The memory model drives bus_ready low from the first strobe cycle through W cycles, then high. While ready is low it drives bus_data as the bitwise complement of the valid word. The valid word for address a is {a XOR 8'hA5, a}, with the upper byte first.
- R8: req_start is ignored while busy is 1, including in the done cycle. busy is 1 from the first phase through the done cycle and 0 in the cycle after it.
- R9: done is a single-cycle pulse with bus_rd low. rd_data keeps the captured word after done falls.
- R10: A transfer lasts 3 + W cycles from the sampling edge to the done cycle, for every W in 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start pulse for one read transfer |
| req_addr | input | AW | Address of the requested word |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle pulse: rd_data holds the new word |
| rd_data | output | DW | Last captured word |
| bus_addr | output | AW | Address on the memory bus |
| bus_rd | output | 1 | Read strobe on the memory bus |
| bus_ready | output | 1 | Ready line driven by the memory model |
| bus_data | output | DW | Data bus driven by the memory model |

## Verification
A fixed set of addresses is run through four copies of the block, one for each wait count from 0 to 3. The addresses include all-zero, all-one, alternating and single-bit patterns. Running each address at every wait count separates a capture that comes one edge too early, which returns the complemented not-ready word, from one that comes too late, which shows up as a longer transfer. The counts of strobe and not-ready cycles tell an uncounted wait state apart from an extra one.

Directed cases cover the following:
- a second start, with a different address, pushed in mid-transfer and again in the done cycle;
- a reset that arrives in the middle of a transfer.

// File: rtl/rdbus_pkg.sv
package rdbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_STRB,
      ST_WAIT,
      ST_DONE
   } rd_state_e;
endpackage

// File: rtl/rdbus_master.sv
module rdbus_master
   import rdbus_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_start,
   input  logic [AW-1:0] req_addr,
   input  logic          bus_ready,
   input  logic [DW-1:0] bus_data,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] bus_addr,
   output logic          bus_rd
);
   rd_state_e     state_q, state_d;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic          strobe_ph;

   assign strobe_ph = (state_q == ST_STRB) || (state_q == ST_WAIT);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (req_start) state_d = ST_ADDR;
         ST_ADDR: state_d = ST_STRB;
         ST_STRB,
         ST_WAIT: state_d = bus_ready ? ST_DONE : ST_WAIT;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_start) addr_q <= req_addr;
         if (strobe_ph && bus_ready)          data_q <= bus_data;
      end
   end

   assign bus_addr = addr_q;
   assign bus_rd   = strobe_ph;
   assign busy     = (state_q != ST_IDLE);
   assign done     = (state_q == ST_DONE);
   assign rd_data  = data_q;

   // R3: address held through every strobe cycle
   p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> $stable(bus_addr));
   // R5: a not-ready strobe cycle is followed by another strobe cycle
   p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));
   // R6: the returned word is the one on the bus at the ready edge
   p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_ready) |=> (done && rd_data == $past(bus_data)));
   // R8: a transfer only begins from idle
   p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADDR) |-> ($past(state_q) == ST_IDLE));
   // R9: done is a single pulse with the strobe released
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !bus_rd));
endmodule

// File: rtl/rdbus_waitgen.sv
module rdbus_waitgen #(
   parameter int            AW    = 8,
   parameter int            DW    = 16,
   parameter int            WAITS = 1,
   parameter logic [AW-1:0] SALT  = 'hA5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_rd,
   output logic          bus_ready,
   output logic [DW-1:0] bus_data
);
   logic [DW-1:0] word;

   if (DW != 2 * AW) begin : g_bad_width
      $error("rdbus_waitgen: DW must be twice AW");
   end

   assign word = {bus_addr ^ SALT, bus_addr};

   if (WAITS == 0) begin : g_zero_wait
      assign bus_ready = 1'b1;
      assign bus_data  = word;
   end else begin : g_counted_wait
      localparam int            CW   = (WAITS > 1) ? $clog2(WAITS + 1) : 1;
      localparam logic [CW-1:0] WLIM = CW'(WAITS);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (!bus_rd)        cnt_q <= '0;
         else if (cnt_q != WLIM)  cnt_q <= cnt_q + 1'b1;
      end

      assign bus_ready = !bus_rd || (cnt_q == WLIM);
      assign bus_data  = (bus_rd && cnt_q == WLIM) ? word : ~word;

      // R7: ready drops in the first strobe cycle when waits are configured
      p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(bus_rd) |-> !bus_ready);
   end
endmodule

// File: rtl/rdbus_read_sys.sv
module rdbus_read_sys #(
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int WAITS = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_start,
   input  logic [AW-1:0] req_addr,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] bus_addr,
   output logic          bus_rd,
   output logic          bus_ready,
   output logic [DW-1:0] bus_data
);
   localparam int LW = 3;
   localparam logic [LW-1:0] EXP_LEN = LW'(WAITS + 2);

   if (WAITS < 0 || WAITS > 3) begin : g_bad_waits
      $error("rdbus_read_sys: WAITS must be 0 to 3");
   end
   if (AW < 1) begin : g_bad_aw
      $error("rdbus_read_sys: AW must be positive");
   end

   rdbus_master #(.AW(AW), .DW(DW)) u_master (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_start (req_start),
      .req_addr  (req_addr),
      .bus_ready (bus_ready),
      .bus_data  (bus_data),
      .busy      (busy),
      .done      (done),
      .rd_data   (rd_data),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd)
   );

   rdbus_waitgen #(.AW(AW), .DW(DW), .WAITS(WAITS)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_ready (bus_ready),
      .bus_data  (bus_data)
   );

   logic [LW-1:0] len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             len_q <= '0;
      else if (!busy || done) len_q <= '0;
      else                    len_q <= len_q + 1'b1;
   end

   // R10: busy cycles before done match the configured wait count
   p_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (len_q == EXP_LEN));
   // R8: done only inside a busy window
   p_busy_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
endmodule

// File: tb/tb_rdbus_read_sys.sv
module tb_rdbus_read_sys;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int NW = 4;
   localparam int NV = 8;
   localparam logic [AW-1:0] VEC_ADDR [NV] =
      '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h01, 8'h80, 8'h3C, 8'hC3};

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [NW-1:0] start_v = '0;
   logic [AW-1:0] req_addr = '0;
   wire  [NW-1:0] busy_v, done_v, rd_v, rdy_v;
   wire  [AW-1:0] baddr_v [NW];
   wire  [DW-1:0] data_v  [NW];
   wire  [DW-1:0] bdata_v [NW];

   for (genvar gw = 0; gw < NW; gw++) begin : g_w
      rdbus_read_sys #(.AW(AW), .DW(DW), .WAITS(gw)) dut (
         .clk       (clk),
         .rst_n     (rst_n),
         .req_start (start_v[gw]),
         .req_addr  (req_addr),
         .busy      (busy_v[gw]),
         .done      (done_v[gw]),
         .rd_data   (data_v[gw]),
         .bus_addr  (baddr_v[gw]),
         .bus_rd    (rd_v[gw]),
         .bus_ready (rdy_v[gw]),
         .bus_data  (bdata_v[gw])
      );
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
      return {a ^ 8'hA5, a};
   endfunction

   task automatic run(input int w, input logic [AW-1:0] a, input bit poke);
      int n, rdc, rdylo, addr_bad, junk_bad;
      @(negedge clk);
      req_addr   = a;
      start_v[w] = 1'b1;
      @(negedge clk);
      start_v[w] = 1'b0;
      check(baddr_v[w] == a && !rd_v[w] && busy_v[w], "R2 first phase",
            {rd_v[w], busy_v[w], baddr_v[w]}, {2'b01, a});
      n = 1; rdc = 0; rdylo = 0; addr_bad = 0; junk_bad = 0;
      while (!done_v[w] && n < 20) begin
         if (rd_v[w]) begin
            rdc++;
            if (baddr_v[w] != a) addr_bad++;
            if (!rdy_v[w]) begin
               rdylo++;
               if (bdata_v[w] != ~word_of(a)) junk_bad++;
            end
         end
         if (poke && n == 2) begin
            req_addr   = ~a;
            start_v[w] = 1'b1;
         end else if (poke && n == 3) begin
            start_v[w] = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      check(n == 3 + w, (w == 0) ? "R4 no-wait length" : "R10 length", n, 3 + w);
      check(rdc == 1 + w, "R5 strobe cycles", rdc, 1 + w);
      check(addr_bad == 0, "R3 address hold", addr_bad, 0);
      check(rdylo == w, "R7 not-ready cycles", rdylo, w);
      check(junk_bad == 0, "R7 not-ready data", junk_bad, 0);
      check(data_v[w] == word_of(a), "R6 captured word", data_v[w], word_of(a));
      check(!rd_v[w] && busy_v[w], "R9 strobe low at done", {rd_v[w], busy_v[w]}, 2'b01);
      if (poke) begin
         req_addr   = ~a;
         start_v[w] = 1'b1;
         @(negedge clk);
         start_v[w] = 1'b0;
         check(!busy_v[w] && !done_v[w], "R8 start ignored", {busy_v[w], done_v[w]}, 2'b00);
         check(baddr_v[w] == a, "R8 address kept", baddr_v[w], a);
         check(data_v[w] == word_of(a), "R9 data held", data_v[w], word_of(a));
         @(negedge clk);
         check(!busy_v[w], "R8 no late transfer", busy_v[w], 0);
      end else begin
         @(negedge clk);
         check(!done_v[w] && !busy_v[w], "R9 single pulse", {done_v[w], busy_v[w]}, 2'b00);
         check(data_v[w] == word_of(a), "R9 data held", data_v[w], word_of(a));
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      for (int w = 0; w < NW; w++) begin
         check(!rd_v[w] && baddr_v[w] == '0 && !busy_v[w] && !done_v[w] && data_v[w] == '0,
               "R1 reset state", {rd_v[w], busy_v[w], done_v[w], baddr_v[w]}, 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      for (int w = 0; w < NW; w++) begin
         check(!busy_v[w] && !rd_v[w], "R1 idle after reset", {busy_v[w], rd_v[w]}, 0);
      end

      for (int w = 0; w < NW; w++) begin
         for (int v = 0; v < NV; v++) begin
            run(w, VEC_ADDR[v], 1'b0);
         end
      end

      run(2, 8'h69, 1'b1);
      run(3, 8'h96, 1'b1);

      // R1: reset in the middle of a transfer
      @(negedge clk);
      req_addr   = 8'h77;
      start_v[3] = 1'b1;
      @(negedge clk);
      start_v[3] = 1'b0;
      @(negedge clk);
      check(rd_v[3], "R3 strobe before reset", rd_v[3], 1);
      rst_n = 1'b0;
      #1;
      check(!rd_v[3] && baddr_v[3] == '0 && !busy_v[3] && data_v[3] == '0,
            "R1 mid-transfer reset", {rd_v[3], busy_v[3], baddr_v[3]}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_v[3], "R1 idle after mid reset", busy_v[3], 0);
      run(3, 8'h42, 1'b0);

      finish_run();
   end
endmodule